// File: doc/BRIEF.md
# Hierarchical Interrupt Controller with Indirect Line Configuration

This block collects up to 256 interrupt request lines and condenses them into a three-level summary tree: eight-line blocks, eight-block masters and one root byte. A host reaches the block over a small register bus with 16-bit addresses and 8-bit data, and it receives one interrupt output. The output stays high as long as any enabled line holds a latched pending bit.

Per-line settings are not memory-mapped one by one. The host writes a block number into a select register. It then writes a command byte that names one of the eight lines in that block, sets its detection mode and mask bits, and can also clear its latched pending bit. An interrupt service routine walks the tree downward: it reads the root byte, then the master bytes that are flagged, then selects each flagged block and reads its pending byte. It acknowledges a line by rewriting that line's configuration with the clear bit set.

The register bus is a request/response stream. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. A read returns its byte on the response channel, which holds `rsp_valid` and `rsp_rdata` until `rsp_ready` is seen. While a read response is waiting, `req_ready` is low, so at most one read is in flight. Writes produce no response.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset, every line has both mask bits set and level mode off, all pending bits are zero, the block select reads 0, and `irq_o` is low.
- R2: Register offsets from BASE_ADDR (default 0x1BB):
  - +0 root
  - +1..+4 master 0..3
  - +5 block select, 5 bits read back in bits 4:0
  - +6 pending byte of the selected block
  - +7 line command, which reads as 0
  - +8 raw level byte of the selected block
- R3: Root bit 0 always reads 0. Root bit m+1 is 1 exactly when master m has any bit set, and bits 7:5 read 0. `irq_o` is high exactly when the root byte is non-zero.
- R4: Bit b of master m is 1 when block m*8+b has any reported pending line. Bit i of the pending byte of block k reports line k*8+i. A pending bit is reported only while at least one of the line's two mask bits is clear.
- R5: Command byte layout:
  - bit 0: level mode
  - bit 1: falling mask
  - bit 2: rising mask
  - bit 3: clear
  - bits 6:4: line index within the selected block
  - bit 7: commit

  A command with bit 7 at 0 changes nothing.
- R6: In edge mode, a rising input edge latches pending when the rising mask is 0, and a falling edge latches pending when the falling mask is 0. Both edges may be enabled together.
- R7: In level mode, pending is latched while the input is high with the rising mask at 0, or low with the falling mask at 0. A clear issued while the line is still active is followed by a new latch.
- R8: The clear bit empties the addressed line's pending bit and is not stored. Later events still latch, and pending stays set until a clear.
- R9: Writing the stored setting with both mask bits and the clear bit set silences a line: edges no longer latch and nothing is reported. Rewriting the stored setting restores detection.
- R10: The raw level byte returns the synchronised input levels of the selected block, whatever their mask state.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds its value.
- R12: An input change applied before clock edge 1 latches pending at edge 3, which is two synchronising flops plus the pending register. `irq_o` is still low after edge 2 and high after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Asynchronous interrupt request lines |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Host accepts read data |
| rsp_rdata | output | 8 | Read data |
| irq_o | output | 1 | Interrupt to host |

## Verification
A wrong pending or configuration bit in one line cell shows up in three places within a few cycles: the selected block's pending byte, the master bit that covers it and the root bit that covers that master. It also shows on `irq_o`, without any bus access, in the cycle after the pending register updates. A wrong select register or index decode makes a command land on a neighbouring line, which appears as a missing latch on the intended line and a spurious latch elsewhere after the next input edge. Synchroniser latency errors move the `irq_o` rising edge off clock edge 3 and are caught by sampling either side of it.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int unsigned LINES_PER_BLOCK   = 8;
  localparam int unsigned BLOCKS_PER_MASTER = 8;
  localparam int unsigned MAX_MASTERS       = 4;
  localparam int unsigned PAD_BLOCKS        = MAX_MASTERS * BLOCKS_PER_MASTER;
  localparam int unsigned PAD_LINES         = PAD_BLOCKS * LINES_PER_BLOCK;
  localparam int unsigned SEL_W             = $clog2(PAD_BLOCKS);
  localparam int unsigned LINE_W            = $clog2(PAD_LINES);

  // register offsets relative to the base address
  localparam logic [15:0] OFS_ROOT  = 16'd0;
  localparam logic [15:0] OFS_MSTR0 = 16'd1;
  localparam logic [15:0] OFS_BSEL  = 16'd5;
  localparam logic [15:0] OFS_PEND  = 16'd6;
  localparam logic [15:0] OFS_CMD   = 16'd7;
  localparam logic [15:0] OFS_RAW   = 16'd8;

  // command byte fields
  localparam int unsigned CB_LVL = 0;
  localparam int unsigned CB_MFE = 1;
  localparam int unsigned CB_MRE = 2;
  localparam int unsigned CB_CLR = 3;
  localparam int unsigned CB_IDX = 4;
  localparam int unsigned CB_GO  = 7;

  typedef struct packed {
    logic lvl;
    logic mask_fe;
    logic mask_re;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{lvl: 1'b0, mask_fe: 1'b1, mask_re: 1'b1};
endpackage

// File: rtl/itc_line.sv
module itc_line
  import itc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_i,
  input  logic      cfg_we_i,
  input  line_cfg_t cfg_i,
  input  logic      clr_i,
  output logic      pend_o,
  output logic      level_o
);
  logic      sync1_q, sync2_q, prev_q;
  logic      pend_q;
  line_cfg_t cfg_q;
  logic      rise, fall, active, set_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise    = sync2_q & ~prev_q;
  assign fall    = ~sync2_q & prev_q;
  assign active  = (sync2_q & ~cfg_q.mask_re) | (~sync2_q & ~cfg_q.mask_fe);
  assign set_evt = cfg_q.lvl ? active
                             : ((rise & ~cfg_q.mask_re) | (fall & ~cfg_q.mask_fe));

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= CFG_RESET;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (clr_i)   pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
  end

  assign pend_o  = pend_q & ~(cfg_q.mask_re & cfg_q.mask_fe);
  assign level_o = sync2_q;

  // R8: a clear pulse empties the latch at the next edge
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !pend_q);
  // R8: pending is sticky until cleared
  p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);
  // R9: a fully masked idle line never latches
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mask_re && cfg_q.mask_fe && !pend_q) |=> !pend_q);
endmodule

// File: rtl/itc_regbus.sv
module itc_regbus
  import itc_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h01BB
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [15:0]                   req_addr,
  input  logic [7:0]                    req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [7:0]                    rsp_rdata,
  input  logic [7:0]                    root_i,
  input  logic [MAX_MASTERS-1:0][7:0]   mstr_i,
  input  logic [7:0]                    pend_sel_i,
  input  logic [7:0]                    raw_sel_i,
  output logic [SEL_W-1:0]              sel_o,
  output logic                          cmd_we_o,
  output logic [LINE_W-1:0]             cmd_line_o,
  output line_cfg_t                     cmd_cfg_o,
  output logic                          cmd_clr_o
);
  logic [15:0]      ofs;
  logic             acc, wr_acc, rd_acc, wr_sel;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       rd_mux;

  assign ofs       = req_addr - BASE_ADDR;
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;
  assign wr_sel    = wr_acc && (ofs == OFS_BSEL);

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= req_wdata[SEL_W-1:0];
  end
  assign sel_o = sel_q;

  assign cmd_we_o   = wr_acc && (ofs == OFS_CMD) && req_wdata[CB_GO];
  assign cmd_clr_o  = cmd_we_o && req_wdata[CB_CLR];
  assign cmd_line_o = {sel_q, req_wdata[CB_IDX +: 3]};
  assign cmd_cfg_o  = '{lvl:     req_wdata[CB_LVL],
                        mask_fe: req_wdata[CB_MFE],
                        mask_re: req_wdata[CB_MRE]};

  always_comb begin
    rd_mux = '0;
    if (ofs == OFS_ROOT) rd_mux = root_i;
    for (int m = 0; m < int'(MAX_MASTERS); m++)
      if (ofs == OFS_MSTR0 + 16'(m)) rd_mux = mstr_i[m];
    if (ofs == OFS_BSEL) rd_mux = 8'(sel_q);
    if (ofs == OFS_PEND) rd_mux = pend_sel_i;
    if (ofs == OFS_RAW)  rd_mux = raw_sel_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11: a stalled response keeps its data
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R2: block select only moves on a write to its offset
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel_q));
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import itc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 256,
  parameter logic [15:0] BASE_ADDR = 16'h01BB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [15:0]          req_addr,
  input  logic [7:0]           req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [7:0]           rsp_rdata,
  output logic                 irq_o
);
  localparam int unsigned NUM_BLOCKS  = NUM_LINES / LINES_PER_BLOCK;
  localparam int unsigned NUM_MASTERS =
    (NUM_BLOCKS + BLOCKS_PER_MASTER - 1) / BLOCKS_PER_MASTER;

  logic [PAD_LINES-1:0]              pend_vec, raw_vec;
  logic [PAD_BLOCKS-1:0]             blk_any;
  logic [MAX_MASTERS-1:0][7:0]       mstr;
  logic [7:0]                        root;
  logic [SEL_W-1:0]                  sel;
  logic                              cmd_we, cmd_clr;
  logic [LINE_W-1:0]                 cmd_line;
  line_cfg_t                         cmd_cfg;

  for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_line
    logic hit;
    assign hit = (cmd_line == LINE_W'(g));
    itc_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (irq_lines[g]),
      .cfg_we_i (cmd_we && hit),
      .cfg_i    (cmd_cfg),
      .clr_i    (cmd_clr && hit),
      .pend_o   (pend_vec[g]),
      .level_o  (raw_vec[g])
    );
  end

  if (PAD_LINES > NUM_LINES) begin : g_pad
    assign pend_vec[PAD_LINES-1:NUM_LINES] = '0;
    assign raw_vec[PAD_LINES-1:NUM_LINES]  = '0;
  end

  for (genvar b = 0; b < int'(PAD_BLOCKS); b++) begin : g_blk
    assign blk_any[b] = |pend_vec[b*LINES_PER_BLOCK +: LINES_PER_BLOCK];
  end

  for (genvar m = 0; m < int'(MAX_MASTERS); m++) begin : g_mstr
    assign mstr[m]   = blk_any[m*BLOCKS_PER_MASTER +: BLOCKS_PER_MASTER];
    assign root[m+1] = (m < int'(NUM_MASTERS)) ? |mstr[m] : 1'b0;
  end
  assign root[0]                = 1'b0;
  assign root[7:MAX_MASTERS+1]  = '0;
  assign irq_o                  = |root;

  itc_regbus #(.BASE_ADDR(BASE_ADDR)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .root_i     (root),
    .mstr_i     (mstr),
    .pend_sel_i (pend_vec[sel*LINES_PER_BLOCK +: LINES_PER_BLOCK]),
    .raw_sel_i  (raw_vec[sel*LINES_PER_BLOCK +: LINES_PER_BLOCK]),
    .sel_o      (sel),
    .cmd_we_o   (cmd_we),
    .cmd_line_o (cmd_line),
    .cmd_cfg_o  (cmd_cfg),
    .cmd_clr_o  (cmd_clr)
  );
endmodule

// File: tb/irq_tree_ctrl_test.sv
module irq_tree_ctrl_test;
  localparam int          NL   = 256;
  localparam logic [15:0] BASE = 16'h01BB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_lines = '0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0]   req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready, rsp_valid, irq_o;
  logic [7:0]    rsp_rdata;

  always #10 clk = ~clk;

  irq_tree_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  bit m_in[NL], m_lvl[NL], m_mfe[NL], m_mre[NL], m_pend[NL];

  function automatic bit vis(int l);
    return m_pend[l] && !(m_mfe[l] && m_mre[l]);
  endfunction
  function automatic bit lvl_active(int l);
    return (m_in[l] && !m_mre[l]) || (!m_in[l] && !m_mfe[l]);
  endfunction
  function automatic logic [7:0] exp_blk(int b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = vis(b*8 + i);
    return r;
  endfunction
  function automatic logic [7:0] exp_raw(int b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m_in[b*8 + i];
    return r;
  endfunction
  function automatic logic [7:0] exp_master(int m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = |exp_blk(m*8 + i);
    return r;
  endfunction
  function automatic logic [7:0] exp_root();
    logic [7:0] r = '0;
    for (int m = 0; m < 4; m++) r[m+1] = |exp_master(m);
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
  endtask

  task automatic read_chk(string tag, logic [15:0] a, logic [7:0] exp);
    logic [7:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  // command: {go, idx[2:0], clr, mre, mfe, lvl}
  task automatic cmd_line(int l, bit lvl, bit mfe, bit mre, bit clr, bit go);
    bus_write(BASE + 16'd5, 8'(l / 8));
    bus_write(BASE + 16'd7, {go, 3'(l % 8), clr, mre, mfe, lvl});
    if (go) begin
      m_lvl[l] = lvl; m_mfe[l] = mfe; m_mre[l] = mre;
      if (clr) m_pend[l] = 0;
      if (lvl && lvl_active(l)) m_pend[l] = 1;
    end
  endtask

  task automatic update_model(int l, bit v);
    bit old = m_in[l];
    m_in[l] = v;
    if (m_lvl[l]) begin
      if (lvl_active(l)) m_pend[l] = 1;
    end else if ((v && !old && !m_mre[l]) || (!v && old && !m_mfe[l])) begin
      m_pend[l] = 1;
    end
  endtask

  task automatic set_line(int l, bit v);
    @(negedge clk);
    irq_lines[l] = v;
    update_model(l, v);
    repeat (5) @(negedge clk);
  endtask

  task automatic check_block(string tag, int b);
    bus_write(BASE + 16'd5, 8'(b));
    read_chk(tag, BASE + 16'd6, exp_blk(b));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    int blks[4] = '{1, 9, 18, 31};
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < NL; i++) begin
      m_mfe[i] = 1; m_mre[i] = 1;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    read_chk("R1 root", BASE, 8'h00);
    read_chk("R1 bsel", BASE + 16'd5, 8'h00);
    read_chk("R1 pending blk0", BASE + 16'd6, 8'h00);
    read_chk("R2 cmd reads zero", BASE + 16'd7, 8'h00);

    // R12 latency on line 10, rising only
    cmd_line(10, 0, 1, 0, 0, 1);
    @(negedge clk);
    irq_lines[10] = 1;
    update_model(10, 1);
    @(negedge clk);
    @(negedge clk);
    check("R12 irq after edge 2", {7'b0, irq_o}, 8'h00);
    @(negedge clk);
    check("R12 irq after edge 3", {7'b0, irq_o}, 8'h01);
    // R3 R4 field positions: line 10 is block 1 bit 2, master 0 bit 1, root bit 1
    read_chk("R3 root", BASE, 8'h02);
    read_chk("R4 master0", BASE + 16'd1, 8'h02);
    read_chk("R4 pending blk1", BASE + 16'd6, 8'h04);
    read_chk("R2 bsel readback", BASE + 16'd5, 8'h01);

    // R8 clear, R6 falling masked
    cmd_line(10, 0, 1, 0, 1, 1);
    check_block("R8 cleared", 1);
    set_line(10, 0);
    check_block("R6 falling masked", 1);
    check("R3 irq low", {7'b0, irq_o}, 8'h00);
    // R6 both edges
    cmd_line(10, 0, 0, 0, 0, 1);
    set_line(10, 1);
    check_block("R6 both rise", 1);
    cmd_line(10, 0, 0, 0, 1, 1);
    set_line(10, 0);
    check_block("R6 both fall", 1);
    // R8 clear not stored: a later edge still latches
    cmd_line(10, 0, 0, 0, 1, 1);
    set_line(10, 1);
    check_block("R8 clear not stored", 1);

    // R9 mask and unmask
    cmd_line(10, 0, 1, 1, 1, 1);
    check_block("R9 masked cleared", 1);
    set_line(10, 0);
    set_line(10, 1);
    check_block("R9 masked no latch", 1);
    check("R9 irq low", {7'b0, irq_o}, 8'h00);
    cmd_line(10, 0, 0, 0, 0, 1);
    set_line(10, 0);
    check_block("R9 unmask restores", 1);
    cmd_line(10, 0, 0, 0, 1, 1);

    // R5 ignored command
    cmd_line(40, 0, 1, 0, 0, 0);
    set_line(40, 1);
    check_block("R5 commit bit 0 ignored", 5);
    set_line(40, 0);

    // R10 raw level of masked line 3
    set_line(3, 1);
    bus_write(BASE + 16'd5, 8'd0);
    read_chk("R10 raw blk0", BASE + 16'd8, 8'h08);
    read_chk("R10 pending blk0", BASE + 16'd6, 8'h00);
    set_line(3, 0);

    // R7 level active high on line 200: block 25, master 3, root bit 4
    cmd_line(200, 1, 1, 0, 0, 1);
    set_line(200, 1);
    read_chk("R7 root", BASE, 8'h10);
    check_block("R7 level high", 25);
    cmd_line(200, 1, 1, 0, 1, 1);
    check_block("R7 relatch after clear", 25);
    set_line(200, 0);
    cmd_line(200, 1, 1, 0, 1, 1);
    check_block("R7 inactive clear", 25);
    // active low
    cmd_line(200, 1, 0, 1, 0, 1);
    check_block("R7 level low", 25);
    cmd_line(200, 0, 1, 1, 1, 1);

    // R11 back-pressure
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = BASE + 16'd5;
    @(negedge clk);
    req_valid = 0;
    d = rsp_rdata;
    check("R11 rsp valid", {7'b0, rsp_valid}, 8'h01);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 ready low", {7'b0, req_ready}, 8'h00);
      check("R11 data held", rsp_rdata, d);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R11 released", {7'b0, rsp_valid}, 8'h00);

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 4);
      int b  = blks[$urandom % 4];
      int l  = b*8 + int'($urandom % 8);
      case (op)
        0: cmd_line(l, 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), ($urandom % 8) != 0);
        1: set_line(l, !m_in[l]);
        2: begin
          check_block("R4 random pending", b);
          read_chk("R10 random raw", BASE + 16'd8, exp_raw(b));
        end
        default: begin
          int m = int'($urandom % 4);
          read_chk("R3 random root", BASE, exp_root());
          read_chk("R4 random master", BASE + 16'(1 + m), exp_master(m));
          check("R3 random irq", {7'b0, irq_o}, {7'b0, |exp_root()});
        end
      endcase
    end

    finish_run();
  end
endmodule